// File: doc/BRIEF.md
# Swallow Counter with Lockout

This block sets the number of output cycles of a dual-modulus prescaler that run at the larger modulus. A synchronous preset strobe loads a binary start value from the frequency-select word. Each prescaler output pulse then counts the value down. While the count runs, the block requests the larger modulus. When the count is exhausted, one more pulse puts the block into a lockout state. In that state the block gates off its own count enable and holds the prescaler at the smaller modulus until the next preset.

The design is fully synchronous in one clock domain. Each prescaler output pulse arrives as a one-cycle enable. If the preset strobe and a pulse fall in the same cycle, the preset wins. A loaded value N gives exactly N+1 large-modulus prescaler cycles per preset period. A value of zero therefore gives a single large-modulus cycle, and the count never wraps.

Top module: `swallow_counter`

## Requirements
- R1: After reset the block is locked: locked_o is 1 and mod_hi_o is 0. Pulses before the first preset leave it locked.
- R2: In the cycle after a preset strobe, locked_o is 0 and mod_hi_o is 1 (larger modulus requested).
- R3: In any cycle where preset_i is 1, mod_hi_o is 0, whatever the counter state.
- R4: When preset_i and pulse_i are both 1 in one cycle, the preset value is loaded and that pulse is not counted.
- R5: After a preset with value N, mod_hi_o is 1 for exactly N+1 counted pulses. In the cycle after pulse N+1, locked_o is 1 and mod_hi_o is 0.
- R6: A preset value of 0 gives one pulse at the larger modulus, then lockout. The count does not wrap.
- R7: While locked, further pulses have no effect: mod_hi_o stays 0 and locked_o stays 1 until the next preset.
- R8: In cycles without a pulse or a preset, the state holds and mod_hi_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One-cycle enable, one per prescaler output cycle |
| preset_i | input | 1 | Synchronous preset strobe |
| preset_val_i | input | CNT_W | Start value for the down-count |
| mod_hi_o | output | 1 | 1 requests the larger modulus, 0 the smaller |
| locked_o | output | 1 | 1 while the lockout state holds |

## Verification
A preset strobe and a prescaler pulse can fall in the same cycle. The bench provokes this by asserting pulse_i together with preset_i at the start of randomly chosen preset windows. It judges the outcome by the number of large-modulus pulses seen before lockout, which must still be exactly N+1.

A scoreboard checks every window against min(pulses sent, N+1), including windows that a new preset cuts short. Inline checks track mod_hi_o and locked_o pulse by pulse, and across idle gaps.

// File: rtl/swallow_pkg.sv
package swallow_pkg;
  localparam int unsigned DEF_CNT_W = 7;

  typedef enum logic {
    MOD_SMALL = 1'b0,
    MOD_LARGE = 1'b1
  } mod_sel_e;
endpackage

// File: rtl/swallow_down_cnt.sv
module swallow_down_cnt #(
  parameter int unsigned CNT_W = swallow_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cnt_en_i,
  output logic             borrow_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign borrow_o = (cnt_q == ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= ZERO;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_en_i && !borrow_o) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == ZERO && !load_i) |=> cnt_q == ZERO);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !cnt_en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/swallow_lockout.sv
module swallow_lockout (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic preset_i,
  input  logic pulse_i,
  input  logic borrow_i,
  output logic cnt_en_o,
  output logic locked_o
);
  logic locked_q;

  // clock-enable gate: closed while locked, preset takes priority
  assign cnt_en_o = pulse_i & ~locked_q & ~preset_i;
  assign locked_o = locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
    end else if (preset_i) begin
      locked_q <= 1'b0;
    end else if (cnt_en_o && borrow_i) begin
      locked_q <= 1'b1;
    end
  end

  p_unlock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> !locked_q);

  p_lock_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && pulse_i && !locked_q && borrow_i) |=> locked_q);

  p_lock_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !preset_i) |=> locked_q);

  p_no_early_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && !borrow_i) |=> !locked_q);
endmodule

// File: rtl/swallow_mod_sel.sv
module swallow_mod_sel
  import swallow_pkg::*;
(
  input  logic     locked_i,
  input  logic     preset_i,
  output mod_sel_e mod_o
);
  // small modulus forced during the preset strobe
  always_comb begin
    if (preset_i || locked_i) mod_o = MOD_SMALL;
    else                      mod_o = MOD_LARGE;
  end
endmodule

// File: rtl/swallow_counter.sv
module swallow_counter
  import swallow_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             preset_i,
  input  logic [CNT_W-1:0] preset_val_i,
  output logic             mod_hi_o,
  output logic             locked_o
);
  logic     borrow;
  logic     cnt_en;
  mod_sel_e mod_sel;

  swallow_down_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (preset_i),
    .load_val_i (preset_val_i),
    .cnt_en_i   (cnt_en),
    .borrow_o   (borrow)
  );

  swallow_lockout u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .preset_i (preset_i),
    .pulse_i  (pulse_i),
    .borrow_i (borrow),
    .cnt_en_o (cnt_en),
    .locked_o (locked_o)
  );

  swallow_mod_sel u_mod (
    .locked_i (locked_o),
    .preset_i (preset_i),
    .mod_o    (mod_sel)
  );

  assign mod_hi_o = (mod_sel == MOD_LARGE);

  p_preset_small_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |-> !mod_hi_o);

  p_locked_small_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !mod_hi_o);

  p_preset_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_i && pulse_i) |=> (!locked_o && mod_hi_o) || preset_i);
endmodule

// File: tb/tb_swallow_counter.sv
module tb_swallow_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pulse_i = 1'b0;
  logic         preset_i = 1'b0;
  logic [W-1:0] val_i = '0;
  logic         mod_hi_o;
  logic         locked_o;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int seen = 0;
  int exp_v = 0;
  bit win_open = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_counter #(.CNT_W(W)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .pulse_i      (pulse_i),
    .preset_i     (preset_i),
    .preset_val_i (val_i),
    .mod_hi_o     (mod_hi_o),
    .locked_o     (locked_o)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic cycle(input bit p, input bit pr, input logic [W-1:0] v);
    @(posedge clk);
    #1;
    pulse_i = p;
    preset_i = pr;
    val_i = v;
    @(negedge clk);
  endtask

  // monitor: counts large-modulus pulses per preset window
  always @(negedge clk) begin
    if (rst_n) begin
      if (preset_i) begin
        if (win_open) begin
          if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R5 actual=%0d expected=<none> (empty scoreboard)", seen);
          end else begin
            exp_v = exp_q.pop_front();
            chk("R5 window count", seen, exp_v);
          end
        end
        win_open = 1'b1;
        seen = 0;
      end else if (pulse_i && mod_hi_o) begin
        seen++;
      end
    end
  end

  task automatic do_window(input int n, input int p, input bit collide, input int gap);
    string t;
    cycle(collide, 1'b1, n[W-1:0]);
    chk("R3", int'(mod_hi_o), 0);
    for (int k = 0; k < p; k++) begin
      for (int g = 0; g < gap; g++) begin
        cycle(1'b0, 1'b0, '0);
        chk("R8", int'(mod_hi_o), (k <= n) ? 1 : 0);
      end
      if (k == 0)      t = collide ? "R4" : "R2";
      else if (k > n)  t = "R7";
      else if (n == 0) t = "R6";
      else             t = "R5";
      cycle(1'b1, 1'b0, '0);
      chk(t, int'(mod_hi_o), (k <= n) ? 1 : 0);
      chk(t, int'(locked_o), (k > n) ? 1 : 0);
    end
    cycle(1'b0, 1'b0, '0);
    chk((n == 0 && p > 0) ? "R6" : "R5", int'(mod_hi_o), (p <= n) ? 1 : 0);
    exp_q.push_back((p < n + 1) ? p : n + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(locked_o), 1);
    chk("R1", int'(mod_hi_o), 0);
    cycle(1'b1, 1'b0, '0);
    cycle(1'b0, 1'b0, '0);
    chk("R1", int'(locked_o), 1);
    chk("R1", int'(mod_hi_o), 0);

    do_window(3, 7, 1'b0, 0);
    do_window(2, 5, 1'b1, 1);
    do_window(0, 3, 1'b0, 0);
    do_window(0, 2, 1'b1, 2);
    do_window(1, 3, 1'b0, 20);
    do_window(5, 2, 1'b0, 0);
    do_window((1 << W) - 1, (1 << W) + 2, 1'b0, 0);

    for (int i = 0; i < 40; i++) begin
      int n;
      int p;
      n = $urandom_range(0, (1 << W) - 1);
      if ($urandom_range(0, 4) == 0) p = $urandom_range(0, n);
      else p = n + 1 + $urandom_range(0, 5);
      do_window(n, p, ($urandom_range(0, 3) == 0), $urandom_range(0, 2));
    end

    cycle(1'b0, 1'b1, '0);
    cycle(1'b0, 1'b0, '0);
    chk("R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule